// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block holds one request flag per interrupt source. Every source has a 2-bit trigger sense that software programs: level, falling edge, rising edge or both edges. On each clock edge the block samples every line and compares it with the sample from the cycle before. It raises a flag when the condition for that source's sense occurs. The flag vector goes to a downstream arbiter, which is a separate block.

The sense also decides who may drop a flag. A level-sensed flag follows its line and clears itself as soon as the line falls. Software writes and acknowledges have no effect on it. An edge-sensed flag stays set until the arbiter acknowledges that source, or until software writes an all-zero byte to the flag. Source 0 is reserved and never requests.

A small register port, with no wait states, exposes the flag and the sense of each source. Reads are combinational. Writes take effect at the next clock edge. The acknowledge is a single-cycle strobe with no back-pressure, so there is no valid/ready stream at this boundary.

Top module: `intreq_bank`

## Requirements
- R1: A write to the sense window stores bits 3:2 of the write byte as the source's sense (0 level, 1 falling edge, 2 rising edge, 3 both edges). A read of that window returns the sense in bits 3:2 and zeros in every other bit.
- R2: In reset, all flags are 0. Sources whose bit is set in `LEVEL_MASK` start with level sense, and all other sources start with rising-edge sense (sense read 0x08).
- R3: For a level-sensed source, the flag after each clock edge equals the line value sampled at that edge. Writes of zero and acknowledges leave it unchanged.
- R4: A rising-edge source sets its flag on a 0-to-1 step of its line. The stored previous level resets to 0, so a line held high through reset sets the flag at the first edge after reset.
- R5: A falling-edge source sets its flag on a 1-to-0 step of its line.
- R6: A both-edges source sets its flag on any change of its line.
- R7: An edge-sensed flag stays set until an acknowledge strobe carries that source's number. An acknowledge for another source leaves it set.
- R8: Writing the byte 0x00 to an edge-sensed flag clears it. Any nonzero write leaves it unchanged.
- R9: Source 0 never sets its flag, whatever its line and sense.
- R10: A read of the flag window returns the flag in bit 0 and zeros in bits 7:1.
- R11: If a trigger condition and a clear (acknowledge or zero write) reach the same source in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; lines are synchronous to it |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_i | input | NUM_SRC | Interrupt lines, one per source |
| ack_valid_i | input | 1 | Acknowledge strobe, one cycle |
| ack_id_i | input | IDX_W | Source number being acknowledged |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Window select: 0 flag, 1 sense |
| reg_idx_i | input | IDX_W | Source number addressed by the register port |
| reg_wdata_i | input | 8 | Write byte |
| reg_rdata_o | output | 8 | Read byte for the addressed window and source |
| pend_o | output | NUM_SRC | Request flags toward the arbiter |

## Verification
A wrong previous-level sample or a wrong decoded sense shows on `pend_o` at the very next clock edge. It appears either as a flag that rises without a matching line transition, or as one that misses a transition. A clear rule routed to the wrong source, or applied to the wrong sense class, shows up one cycle after the acknowledge or write: an edge flag drops that should have held, or a level flag stops tracking its line. Sense storage faults are visible at once through the combinational read of the sense window, with no clock needed.

// File: rtl/intreq_pkg.sv
package intreq_pkg;

  typedef enum logic [1:0] {
    SNS_LEVEL = 2'd0,
    SNS_FALL  = 2'd1,
    SNS_RISE  = 2'd2,
    SNS_BOTH  = 2'd3
  } sense_e;

  // bit position of the sense field in the configuration byte
  localparam int SENSE_LSB = 2;
  localparam int SENSE_W   = 2;
  localparam int REG_W     = 8;

  // trigger condition for a given sense, current and previous sample
  function automatic logic trig_hit(sense_e s, logic cur, logic prv);
    logic hit;
    unique case (s)
      SNS_LEVEL: hit = cur;
      SNS_FALL:  hit = prv & ~cur;
      SNS_RISE:  hit = ~prv & cur;
      SNS_BOTH:  hit = prv ^ cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/intreq_cell.sv
module intreq_cell
  import intreq_pkg::*;
#(
  parameter bit LVL_DEFAULT = 1'b0,
  parameter bit TIED_OFF    = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   line_i,
  input  logic   sense_we_i,
  input  sense_e sense_wdata_i,
  input  logic   sw_clr_i,
  input  logic   ack_i,
  output logic   flag_o,
  output sense_e sense_o,
  output logic   prev_o
);

  localparam sense_e RST_SENSE = LVL_DEFAULT ? SNS_LEVEL : SNS_RISE;

  sense_e sense_q;
  logic   prev_q;
  logic   flag_q;
  logic   flag_d;
  logic   hit;

  assign hit = trig_hit(sense_q, line_i, prev_q);

  always_comb begin
    if (TIED_OFF) begin
      flag_d = 1'b0;
    end else if (sense_q == SNS_LEVEL) begin
      flag_d = line_i;
    end else if (hit) begin
      flag_d = 1'b1;               // a fresh event beats a clear
    end else if (ack_i || sw_clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sense_q <= RST_SENSE;
      prev_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      prev_q <= line_i;
      flag_q <= flag_d;
      if (sense_we_i) sense_q <= sense_wdata_i;
    end
  end

  assign flag_o  = flag_q;
  assign sense_o = sense_q;
  assign prev_o  = prev_q;

endmodule

// File: rtl/intreq_regif.sv
module intreq_regif
  import intreq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic                             reg_wr_i,
  input  logic                             reg_sel_i,
  input  logic [IDX_W-1:0]                 reg_idx_i,
  input  logic [REG_W-1:0]                 reg_wdata_i,
  input  logic [NUM_SRC-1:0]               flags_i,
  input  logic [NUM_SRC-1:0][SENSE_W-1:0]  senses_i,
  output logic [NUM_SRC-1:0]               flag_clr_o,
  output logic [NUM_SRC-1:0]               sense_we_o,
  output sense_e                           sense_wdata_o,
  output logic [REG_W-1:0]                 reg_rdata_o
);

  logic wr_zero;
  assign wr_zero       = (reg_wdata_i == '0);
  assign sense_wdata_o = sense_e'(reg_wdata_i[SENSE_LSB +: SENSE_W]);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
    logic sel;
    assign sel           = reg_wr_i && (reg_idx_i == IDX_W'(g));
    assign flag_clr_o[g] = sel && !reg_sel_i && wr_zero;
    assign sense_we_o[g] = sel && reg_sel_i;
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (reg_idx_i == IDX_W'(k)) begin
        if (reg_sel_i) reg_rdata_o[SENSE_LSB +: SENSE_W] = senses_i[k];
        else           reg_rdata_o[0]                    = flags_i[k];
      end
    end
  end

endmodule

// File: rtl/intreq_bank.sv
module intreq_bank
  import intreq_pkg::*;
#(
  parameter int                NUM_SRC    = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int               IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] line_i,
  input  logic               ack_valid_i,
  input  logic [IDX_W-1:0]   ack_id_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [IDX_W-1:0]   reg_idx_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0]              flag_vec;
  logic [NUM_SRC-1:0]              prev_vec;
  logic [NUM_SRC-1:0][SENSE_W-1:0] sense_vec;
  logic [NUM_SRC-1:0]              flag_clr;
  logic [NUM_SRC-1:0]              sense_we;
  logic [NUM_SRC-1:0]              ack_hit;
  sense_e                          sense_wdata;

  intreq_regif #(
    .NUM_SRC(NUM_SRC),
    .IDX_W  (IDX_W)
  ) regif_i (
    .reg_wr_i     (reg_wr_i),
    .reg_sel_i    (reg_sel_i),
    .reg_idx_i    (reg_idx_i),
    .reg_wdata_i  (reg_wdata_i),
    .flags_i      (flag_vec),
    .senses_i     (sense_vec),
    .flag_clr_o   (flag_clr),
    .sense_we_o   (sense_we),
    .sense_wdata_o(sense_wdata),
    .reg_rdata_o  (reg_rdata_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    sense_e s_out;
    assign ack_hit[g] = ack_valid_i && (ack_id_i == IDX_W'(g));

    intreq_cell #(
      .LVL_DEFAULT(LEVEL_MASK[g]),
      .TIED_OFF   (g == 0)
    ) cell_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .line_i       (line_i[g]),
      .sense_we_i   (sense_we[g]),
      .sense_wdata_i(sense_wdata),
      .sw_clr_i     (flag_clr[g]),
      .ack_i        (ack_hit[g]),
      .flag_o       (flag_vec[g]),
      .sense_o      (s_out),
      .prev_o       (prev_vec[g])
    );
    assign sense_vec[g] = s_out;
  end

  assign pend_o = flag_vec;

endmodule

// File: rtl/intreq_bank_chk.sv
module intreq_bank_chk #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_SRC-1:0]         line_i,
  input logic                       ack_valid_i,
  input logic [IDX_W-1:0]           ack_id_i,
  input logic                       reg_wr_i,
  input logic                       reg_sel_i,
  input logic [IDX_W-1:0]           reg_idx_i,
  input logic [7:0]                 reg_wdata_i,
  input logic [7:0]                 reg_rdata_o,
  input logic [NUM_SRC-1:0]         pend_o,
  input logic [NUM_SRC-1:0]         prev_vec,
  input logic [NUM_SRC-1:0][1:0]    sense_vec
);

  assert_src0_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o[0]);

  assert_flag_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_o[7:1] == 7'd0));

  for (genvar g = 1; g < NUM_SRC; g++) begin : g_chk
    logic ack_m, clr_m;
    assign ack_m = ack_valid_i && (ack_id_i == IDX_W'(g));
    assign clr_m = reg_wr_i && !reg_sel_i && (reg_idx_i == IDX_W'(g)) &&
                   (reg_wdata_i == 8'd0);

    assert_level_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_vec[g] == 2'd0) |=> (pend_o[g] == $past(line_i[g])));

    assert_rise_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_vec[g] == 2'd2 && line_i[g] && !prev_vec[g]) |=> pend_o[g]);

    assert_fall_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_vec[g] == 2'd1 && !line_i[g] && prev_vec[g]) |=> pend_o[g]);

    assert_edge_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_vec[g] != 2'd0 && pend_o[g] && !ack_m && !clr_m) |=> pend_o[g]);
  end

endmodule

bind intreq_bank intreq_bank_chk #(
  .NUM_SRC(NUM_SRC),
  .IDX_W  (IDX_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_i     (line_i),
  .ack_valid_i(ack_valid_i),
  .ack_id_i   (ack_id_i),
  .reg_wr_i   (reg_wr_i),
  .reg_sel_i  (reg_sel_i),
  .reg_idx_i  (reg_idx_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .pend_o     (pend_o),
  .prev_vec   (prev_vec),
  .sense_vec  (sense_vec)
);

// File: tb/intreq_bank_tb_top.sv
module intreq_bank_tb_top;

  localparam int          NSRC  = 16;
  localparam int          IW    = 4;
  localparam logic [15:0] LMASK = 16'h00F0;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] line = '0;
  logic            ack_v = 1'b0;
  logic [IW-1:0]   ack_id = '0;
  logic            wr = 1'b0;
  logic            sel = 1'b0;
  logic [IW-1:0]   idx = '0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic [NSRC-1:0] pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  intreq_bank #(.NUM_SRC(NSRC), .LEVEL_MASK(LMASK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .ack_valid_i(ack_v),
    .ack_id_i(ack_id), .reg_wr_i(wr), .reg_sel_i(sel), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pend_o(pend)
  );

  // entry: [9:8] sense, [7:4] line per step (bit 4 first), [3:0] expected flag per step
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 4'b1101, 4'b1101},
    {2'd2, 4'b1010, 4'b1110},
    {2'd1, 4'b1101, 4'b1110},
    {2'd3, 4'b1100, 4'b1100},
    {2'd2, 4'b0011, 4'b1111},
    {2'd1, 4'b0000, 4'b0000},
    {2'd3, 4'b0001, 4'b1111},
    {2'd0, 4'b0110, 4'b0110}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(logic s, int i, logic [7:0] d);
    wr = 1'b1; sel = s; idx = IW'(i); wdata = d;
    step();
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic reg_read(logic s, int i, output logic [7:0] d);
    sel = s; idx = IW'(i);
    #1 d = rdata;
  endtask

  task automatic ack(int i);
    ack_v = 1'b1; ack_id = IW'(i);
    step();
    ack_v = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    line[9] = 1'b1;                   // held high through reset
    repeat (3) @(negedge clk);
    chk("R2 flags in reset", 8'(pend[7:0]), 8'h00);
    reg_read(1'b1, 5, rd);  chk("R2 level default src5", rd, 8'h00);
    reg_read(1'b1, 2, rd);  chk("R2 rise default src2", rd, 8'h08);
    rst_n = 1'b1;
    step();
    chk("R4 high-at-reset edge src9", 8'(pend[9]), 8'h01);

    // table walk on source 3
    for (int v = 0; v < 8; v++) begin
      line[3] = 1'b0;
      reg_write(1'b1, 3, 8'h00);
      step();
      reg_write(1'b1, 3, {4'h0, VEC[v][9:8], 2'b00});
      for (int k = 0; k < 4; k++) begin
        line[3] = VEC[v][4+k];
        step();
        chk($sformatf("R3/R4/R5/R6 vec%0d step%0d", v, k),
            8'(pend[3]), 8'(VEC[v][k]));
      end
    end

    // R8 software clear on edge flag 9
    reg_write(1'b0, 9, 8'h01);
    chk("R8 nonzero write keeps flag", 8'(pend[9]), 8'h01);
    reg_write(1'b0, 9, 8'h00);
    chk("R8 zero write clears flag", 8'(pend[9]), 8'h00);

    // R3 level source ignores clears
    line[5] = 1'b1; step();
    chk("R3 level follows high", 8'(pend[5]), 8'h01);
    reg_write(1'b0, 5, 8'h00);
    chk("R3 zero write ignored", 8'(pend[5]), 8'h01);
    ack(5);
    chk("R3 ack ignored", 8'(pend[5]), 8'h01);
    line[5] = 1'b0; step();
    chk("R3 level drops with line", 8'(pend[5]), 8'h00);

    // R7 acknowledge
    line[2] = 1'b1; step();
    chk("R4 rise src2", 8'(pend[2]), 8'h01);
    reg_read(1'b0, 2, rd);
    chk("R10 flag readback", rd, 8'h01);
    ack(3);
    chk("R7 foreign ack keeps flag", 8'(pend[2]), 8'h01);
    ack(2);
    chk("R7 own ack clears flag", 8'(pend[2]), 8'h00);

    // R11 event and clear in the same cycle
    line[2] = 1'b0; step();
    line[2] = 1'b1; wr = 1'b1; sel = 1'b0; idx = 4'd2; wdata = 8'h00;
    step();
    wr = 1'b0;
    chk("R11 set wins over clear", 8'(pend[2]), 8'h01);

    // R9 source 0
    reg_write(1'b1, 0, 8'h0C);
    for (int k = 0; k < 4; k++) begin
      line[0] = ~line[0];
      step();
      chk("R9 source 0 silent", 8'(pend[0]), 8'h00);
    end

    // R1 sense field placement
    reg_write(1'b1, 3, 8'hFF);
    reg_read(1'b1, 3, rd);  chk("R1 sense both readback", rd, 8'h0C);
    reg_write(1'b1, 3, 8'hF4);
    reg_read(1'b1, 3, rd);  chk("R1 sense fall readback", rd, 8'h04);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule